// File: doc/BRIEF.md
# DMA and CPU Memory Access Arbiter

This block decides, in every clock cycle, which requester reaches a shared memory port. Five DMA channels and one CPU may request together. Each channel carries a two-bit urgency setting. The block returns a one-hot grant that names the CPU, names one channel, or names nobody. The grant is combinational from the current requests and a small amount of state, so a requester learns in the same cycle whether it owns the port.

Arbitration runs in two stages. In the first stage, the channels that request at the highest urgency present form the candidate set, and a round-robin pointer picks one of them. In the second stage, that channel contends with the CPU, and the outcome depends on the winner's urgency:
- A high-urgency winner always takes the port.
- A low-urgency winner always gives way to the CPU.
- A normal-urgency winner alternates with the CPU through a one-bit memory of who won the last such contest.

Top module: `dma_cpu_arbiter`

## Requirements
- R1: A channel's urgency code in `dma_prio[2*i+1:2*i]` decodes as follows: 2'b00 is low, 2'b01 is normal, and 2'b10 or 2'b11 is high.
- R2: In every cycle, at most one bit of `{grant_cpu, grant_dma}` is set. A channel is granted only in a cycle in which it requests.
- R3: With no requests, both grant outputs are zero. A lone CPU request is granted. DMA requests without a CPU request always produce a DMA grant, whatever their urgency.
- R4: When channels request at different urgencies, the granted channel is one that requests at the highest urgency present.
- R5: Among the candidate channels, the grant goes to the first one found at or after the pointer, searching upward in channel index and wrapping from 4 to 0. The pointer is 0 after reset. It moves to the granted index plus one (modulo 5) only in cycles that issue a DMA grant.
- R6: When the DMA winner is high urgency, it is granted even if the CPU requests in the same cycle.
- R7: When the DMA winner is low urgency and the CPU requests, the CPU is granted.
- R8: When the DMA winner is normal urgency and the CPU requests, the outcome alternates, and the first such contest after reset goes to the CPU. Only these contests flip the alternation, so the DMA side never loses two of them in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU requests the memory port |
| dma_req | input | 5 | Per-channel DMA request |
| dma_prio | input | 10 | Two-bit urgency code per channel, channel i at bits [2i+1:2i] |
| grant_cpu | output | 1 | CPU owns the port this cycle |
| grant_dma | output | 5 | One-hot DMA channel grant |

## Verification
The urgency contest and the DMA-versus-CPU decision act in the same cycle, and both also touch the round-robin state. A case where the CPU wins must leave the pointer untouched, and a high-urgency win must leave the normal-level alternation untouched. The bench provokes both cases with back-to-back cycles of mixed urgencies and a CPU request. It then judges the next grant in the sequence: that grant has to follow from a pointer and a toggle that only the proper events have moved.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    LVL_LOW    = 2'd0,
    LVL_NORMAL = 2'd1,
    LVL_HIGH   = 2'd2
  } level_e;

  // Codes 2'b10 and 2'b11 both mean high urgency.
  function automatic level_e decode_level(input logic [1:0] code);
    if (code[1])      return LVL_HIGH;
    else if (code[0]) return LVL_NORMAL;
    else              return LVL_LOW;
  endfunction

endpackage

// File: rtl/level_filter.sv
module level_filter
  import arb_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic [NUM_CH-1:0]   req_i,
  input  logic [2*NUM_CH-1:0] prio_i,
  output logic [NUM_CH-1:0]   top_mask_o,
  output level_e              top_level_o,
  output logic                any_o
);

  logic [NUM_CH-1:0] is_high;
  logic [NUM_CH-1:0] is_norm;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    level_e lvl;
    assign lvl        = decode_level(prio_i[2*i +: 2]);
    assign is_high[i] = req_i[i] && (lvl == LVL_HIGH);
    assign is_norm[i] = req_i[i] && (lvl == LVL_NORMAL);
  end

  always_comb begin
    any_o = |req_i;
    if (|is_high) begin
      top_level_o = LVL_HIGH;
      top_mask_o  = is_high;
    end else if (|is_norm) begin
      top_level_o = LVL_NORMAL;
      top_mask_o  = is_norm;
    end else begin
      top_level_o = LVL_LOW;
      top_mask_o  = req_i;
    end
  end

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int NUM_CH = 5,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              advance_i,
  output logic [IDX_W-1:0]  pick_o
);

  logic [IDX_W-1:0] ptr_q;

  // First set bit at or after start, searching upward and wrapping.
  function automatic logic [IDX_W-1:0] first_from(input logic [NUM_CH-1:0] m,
                                                  input logic [IDX_W-1:0]  start);
    logic [IDX_W-1:0] r;
    logic found;
    int j;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      j = int'(start) + k;
      if (j >= NUM_CH) j = j - NUM_CH;
      if (!found && m[j]) begin
        r = IDX_W'(j);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign pick_o = first_from(mask_i, ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance_i) begin
      ptr_q <= (pick_o == IDX_W'(NUM_CH - 1)) ? '0 : pick_o + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(ptr_q)); // R5
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < IDX_W'(NUM_CH)); // R5
  AST_PICK_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |-> mask_i[pick_o]); // R5

endmodule

// File: rtl/cpu_dma_decider.sv
module cpu_dma_decider
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dma_any_i,
  input  level_e win_level_i,
  input  logic   cpu_req_i,
  output logic   dma_wins_o,
  output logic   cpu_grant_o,
  output logic   contested_normal_o
);

  logic cpu_won_last_q;

  assign contested_normal_o = dma_any_i && cpu_req_i && (win_level_i == LVL_NORMAL);

  always_comb begin
    if (!dma_any_i)                     dma_wins_o = 1'b0;
    else if (!cpu_req_i)                dma_wins_o = 1'b1;
    else if (win_level_i == LVL_HIGH)   dma_wins_o = 1'b1;
    else if (win_level_i == LVL_NORMAL) dma_wins_o = cpu_won_last_q;
    else                                dma_wins_o = 1'b0;
  end

  assign cpu_grant_o = cpu_req_i && !dma_wins_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_won_last_q <= 1'b0;
    end else if (contested_normal_o) begin
      cpu_won_last_q <= ~cpu_won_last_q;
    end
  end

  AST_NORMAL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    contested_normal_o && $past(contested_normal_o && cpu_grant_o) |-> dma_wins_o); // R8
  AST_HIGH_BEATS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    dma_any_i && (win_level_i == LVL_HIGH) |-> dma_wins_o && !cpu_grant_o); // R6
  AST_LOW_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_any_i && cpu_req_i && (win_level_i == LVL_LOW) |-> cpu_grant_o); // R7

endmodule

// File: rtl/dma_cpu_arbiter.sv
module dma_cpu_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CH = 5,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic [NUM_CH-1:0]   dma_req,
  input  logic [2*NUM_CH-1:0] dma_prio,
  output logic                grant_cpu,
  output logic [NUM_CH-1:0]   grant_dma
);

  logic [NUM_CH-1:0] top_mask;
  level_e            top_level;
  logic              dma_any;
  logic [IDX_W-1:0]  pick_idx;
  logic              dma_wins;
  logic              contested_normal;

  level_filter #(.NUM_CH(NUM_CH)) u_filter (
    .req_i       (dma_req),
    .prio_i      (dma_prio),
    .top_mask_o  (top_mask),
    .top_level_o (top_level),
    .any_o       (dma_any)
  );

  rr_picker #(.NUM_CH(NUM_CH)) u_rr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_i    (top_mask),
    .advance_i (dma_wins),
    .pick_o    (pick_idx)
  );

  cpu_dma_decider u_decide (
    .clk                (clk),
    .rst_n              (rst_n),
    .dma_any_i          (dma_any),
    .win_level_i        (top_level),
    .cpu_req_i          (cpu_req),
    .dma_wins_o         (dma_wins),
    .cpu_grant_o        (grant_cpu),
    .contested_normal_o (contested_normal)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
    assign grant_dma[i] = dma_wins && (pick_idx == IDX_W'(i));
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_cpu, grant_dma})); // R2
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_dma & ~dma_req) == '0); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req && !(|dma_req) |-> !grant_cpu && grant_dma == '0); // R3
  AST_DMA_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req && (|dma_req) |-> $countones(grant_dma) == 1); // R3
  AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_dma) |-> (grant_dma & top_mask) != '0); // R4
  AST_NORMAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    contested_normal |-> cpu_req && (|dma_req)); // R8

endmodule

// File: tb/dma_cpu_arbiter_bench.sv
`timescale 1ns/100ps
module dma_cpu_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0;
  logic [4:0] dma_req = '0;
  logic [9:0] dma_prio = '0;
  logic       grant_cpu;
  logic [4:0] grant_dma;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_cpu_arbiter u_dma_cpu_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .dma_req   (dma_req),
    .dma_prio  (dma_prio),
    .grant_cpu (grant_cpu),
    .grant_dma (grant_dma)
  );

  typedef struct packed {
    logic       cpu;
    logic [4:0] req;
    logic [9:0] prio;
    logic       exp_cpu;
    logic [4:0] exp_dma;
    logic [7:0] rq;
  } vec_t;

  // Urgency codes: 00 low, 01 normal, 10/11 high; channel i at [2i+1:2i].
  // Entries are applied in order from reset; pointer and toggle carry over.
  localparam vec_t VECS [16] = '{
    '{1'b0, 5'b00000, 10'b0000000000, 1'b0, 5'b00000, 8'd3}, // R3 idle
    '{1'b1, 5'b00000, 10'b0000000000, 1'b1, 5'b00000, 8'd3}, // R3 cpu alone
    '{1'b0, 5'b00110, 10'b0000000000, 1'b0, 5'b00010, 8'd5}, // R5 ptr0 -> ch1
    '{1'b0, 5'b00110, 10'b0000000000, 1'b0, 5'b00100, 8'd5}, // R5 ptr2 -> ch2
    '{1'b0, 5'b00110, 10'b0000000000, 1'b0, 5'b00010, 8'd5}, // R5 wrap -> ch1
    '{1'b1, 5'b11111, 10'b0010000000, 1'b0, 5'b01000, 8'd6}, // R6 high ch3
    '{1'b1, 5'b00011, 10'b0000000000, 1'b1, 5'b00000, 8'd7}, // R7 low yields
    '{1'b1, 5'b00101, 10'b0000010001, 1'b1, 5'b00000, 8'd8}, // R8 first to cpu
    '{1'b1, 5'b00101, 10'b0000010001, 1'b0, 5'b00001, 8'd8}, // R8 dma, wrap ch0
    '{1'b1, 5'b00101, 10'b0000010001, 1'b1, 5'b00000, 8'd8}, // R8 cpu again
    '{1'b0, 5'b00101, 10'b0000010001, 1'b0, 5'b00100, 8'd3}, // R3 uncontested
    '{1'b1, 5'b00101, 10'b0000010001, 1'b0, 5'b00001, 8'd8}, // R8 toggle kept
    '{1'b1, 5'b10001, 10'b1000000001, 1'b0, 5'b10000, 8'd4}, // R4 high ch4
    '{1'b1, 5'b00010, 10'b0000000100, 1'b1, 5'b00000, 8'd8}, // R8 untouched by R6 win
    '{1'b0, 5'b11000, 10'b0111000000, 1'b0, 5'b01000, 8'd1}, // R1 code 11 beats 01
    '{1'b1, 5'b01000, 10'b0011000000, 1'b0, 5'b01000, 8'd1}  // R1 code 11 beats cpu
  };

  task automatic check(input logic ecpu, input logic [4:0] edma, input string tag);
    checks++;
    if (grant_cpu !== ecpu || grant_dma !== edma) begin
      failures++;
      $display("FAIL %s: grant_cpu=%b grant_dma=%b expected grant_cpu=%b grant_dma=%b",
               tag, grant_cpu, grant_dma, ecpu, edma);
    end
  endtask

  task automatic apply(input logic c, input logic [4:0] r, input logic [9:0] p);
    @(negedge clk);
    cpu_req  = c;
    dma_req  = r;
    dma_prio = p;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req = 1'b0;
    dma_req = '0;
    dma_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check(1'b0, 5'b00000, "R3 reset state");

    for (int v = 0; v < 16; v++) begin
      apply(VECS[v].cpu, VECS[v].req, VECS[v].prio);
      check(VECS[v].exp_cpu, VECS[v].exp_dma, $sformatf("R%0d vector %0d", VECS[v].rq, v));
    end

    // R5: CPU wins do not move the pointer.
    do_reset();
    apply(1'b1, 5'b00110, 10'b0);
    check(1'b1, 5'b00000, "R7 low channels yield");
    apply(1'b1, 5'b00110, 10'b0);
    check(1'b1, 5'b00000, "R7 low channels yield again");
    apply(1'b0, 5'b00110, 10'b0);
    check(1'b0, 5'b00010, "R5 pointer held while cpu won");

    // Reset restores pointer and toggle.
    apply(1'b1, 5'b00100, 10'b0000010000);
    check(1'b1, 5'b00000, "R8 first contest to cpu");
    do_reset();
    apply(1'b1, 5'b00100, 10'b0000010000);
    check(1'b1, 5'b00000, "R8 toggle cleared by reset");
    apply(1'b1, 5'b00100, 10'b0000010000);
    check(1'b0, 5'b00100, "R8 dma after cpu");

    // R4: normal beats low even at lower index position relative to pointer.
    apply(1'b0, 5'b11111, 10'b0000000100);
    check(1'b0, 5'b00010, "R4 lone normal beats lows");

    // R2: a high request from a non-requesting channel has no effect.
    apply(1'b1, 5'b00001, 10'b1010101000);
    check(1'b1, 5'b00000, "R2 idle channels with high code ignored");

    // R6 with only one high among five.
    apply(1'b1, 5'b11111, 10'b0000001000);
    check(1'b0, 5'b00010, "R6 high ch1 beats cpu");

    apply(1'b0, 5'b00000, 10'b0);
    check(1'b0, 5'b00000, "R3 idle at end");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule